// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary and Line Controller

This block folds the pending requests of up to 184 pins into a compact summary bitmap and drives a single interrupt line toward the processor. Every summary bit stands for a group of four neighbouring pins and is set while any of them is pending. The pins are arranged in banks that begin at pin 0, 64 and 128; each bank reduces its own pins to group bits, and the bits are then placed side by side. The summary is registered once and shown in two 32-bit status words. Software reads these words to find which groups need attention, then inspects the pins of those groups.

A small master register holds a global enable bit and an end-of-service bit. Once the processor line is raised, it stays high until software writes the end-of-service bit. The individual sources need no acknowledge at all. If requests are still pending when end-of-service is written, the line drops for one cycle and then comes back. Clearing the enable bit forces the line low and keeps it low.

Top module: `irq_group_summary`

## Requirements
- R1: After reset, both status words, the master read-back word and the processor line are all zero.
- R2: Summary bit k is set exactly when at least one of pins 4k, 4k+1, 4k+2 and 4k+3 is pending. The status words show the pin vector sampled at the previous rising clock edge.
- R3: Status word 0 carries summary bits 0 to 31 in bit order. Bits 0 to 13 of status word 1 carry summary bits 32 to 45.
- R4: Bits 14 to 31 of status word 1 always read as zero.
- R5: The line rises at the clock edge that follows a cycle in which it was low, the enable bit was set, the status words were non-zero and no master write took place.
- R6: Once high, the line stays high on every edge without a master write, even after all pins have cleared.
- R7: A master write with bit 1 (end-of-service) set drives the line low at that edge. If the status words are still non-zero, the line is high again one edge later.
- R8: Master bit 0 is the enable bit and reads back as last written. Bit 1 is self-clearing and always reads as 0, and all other bits read as 0.
- R9: While the enable bit is 0, the line is low and pending pins do not raise it. The status words still track the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_pend_i | input | 184 | Per-pin pending requests |
| mst_wr_en_i | input | 1 | Master register write strobe |
| mst_wr_data_i | input | 32 | Master register write data (bit 0 enable, bit 1 end-of-service) |
| mst_rd_data_o | output | 32 | Master register read-back |
| stat_w0_o | output | 32 | Summary bits 0 to 31 |
| stat_w1_o | output | 32 | Summary bits 32 to 45, upper bits zero |
| cpu_irq_o | output | 1 | Combined interrupt line to the processor |

## Verification
The assertions assume that a pin's pending request is a synchronous level that only changes between clock edges. They also assume that every master write is a one-cycle strobe, so a single write cannot be read as two end-of-service events. The stimulus changes pins and write data only on falling edges and drops the write strobe after exactly one cycle. It checks outputs on the next falling edge, once the registered summary and the line register have both settled.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;

    // master register bit positions
    localparam int MST_EN_BIT  = 0;
    localparam int MST_EOI_BIT = 1;
    localparam int MST_W       = 32;

    typedef struct packed {
        logic en;
        logic irq;
    } mst_state_t;

endpackage

// File: rtl/irqsum_bank.sv
module irqsum_bank #(
    parameter int PINS  = 64,
    parameter int GROUP = 4
) (
    input  logic [PINS-1:0]         pins_i,
    output logic [PINS/GROUP-1:0]   grp_o
);
    localparam int GRPS = PINS / GROUP;

    for (genvar g = 0; g < GRPS; g++) begin : g_grp
        assign grp_o[g] = |pins_i[g*GROUP +: GROUP];
    end

endmodule

// File: rtl/irqsum_status.sv
module irqsum_status #(
    parameter int NUM_GROUPS = 46,
    parameter int STAT_W     = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_GROUPS-1:0] grp_i,
    output logic [STAT_W-1:0]     stat_o,
    output logic                  any_o
);
    localparam int PAD_W = STAT_W - NUM_GROUPS;

    logic [NUM_GROUPS-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = grp_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sum_q <= '0;
        else         sum_q <= sum_d;
    end

    assign stat_o = {{PAD_W{1'b0}}, sum_q};
    assign any_o  = |sum_q;

endmodule

// File: rtl/irqsum_master.sv
module irqsum_master
    import irqsum_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             any_i,
    input  logic             wr_en_i,
    input  logic [MST_W-1:0] wr_data_i,
    output logic [MST_W-1:0] rd_data_o,
    output logic             irq_o
);
    mst_state_t st_d, st_q;
    logic       eoi;

    always_comb begin
        st_d = st_q;
        eoi  = wr_en_i & wr_data_i[MST_EOI_BIT];
        if (wr_en_i) st_d.en = wr_data_i[MST_EN_BIT];
        if (!st_d.en || eoi) begin
            st_d.irq = 1'b0;
        end else if (!st_q.irq && st_q.en && any_i) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data_o             = '0;
        rd_data_o[MST_EN_BIT] = st_q.en;
    end
    assign irq_o = st_q.irq;

    AST_RAISE_WHEN_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && st_q.en && any_i && !wr_en_i) |=> irq_o); // R5
    AST_HOLD_UNTIL_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !wr_en_i) |=> irq_o); // R6
    AST_EOI_DROPS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[MST_EOI_BIT]) |=> !irq_o); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.en |-> !irq_o); // R9

endmodule

// File: rtl/irq_group_summary.sv
module irq_group_summary
    import irqsum_pkg::*;
#(
    parameter int NUM_PINS  = 184,
    parameter int GROUP     = 4,
    parameter int BANK_PINS = 64,
    parameter int WORD_W    = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_pend_i,
    input  logic                mst_wr_en_i,
    input  logic [31:0]         mst_wr_data_i,
    output logic [31:0]         mst_rd_data_o,
    output logic [WORD_W-1:0]   stat_w0_o,
    output logic [WORD_W-1:0]   stat_w1_o,
    output logic                cpu_irq_o
);
    localparam int NUM_GROUPS = NUM_PINS / GROUP;
    localparam int NUM_BANKS  = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
    localparam int STAT_W     = 2 * WORD_W;

    logic [NUM_GROUPS-1:0] grp_vec;
    logic [STAT_W-1:0]     stat;
    logic                  any_pend;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_PINS;
        localparam int N  = (NUM_PINS - LO < BANK_PINS) ? (NUM_PINS - LO) : BANK_PINS;
        irqsum_bank #(
            .PINS  (N),
            .GROUP (GROUP)
        ) i_bank (
            .pins_i (pin_pend_i[LO +: N]),
            .grp_o  (grp_vec[LO/GROUP +: N/GROUP])
        );
    end

    irqsum_status #(
        .NUM_GROUPS (NUM_GROUPS),
        .STAT_W     (STAT_W)
    ) i_status (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .grp_i  (grp_vec),
        .stat_o (stat),
        .any_o  (any_pend)
    );

    irqsum_master i_master (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .any_i     (any_pend),
        .wr_en_i   (mst_wr_en_i),
        .wr_data_i (mst_wr_data_i),
        .rd_data_o (mst_rd_data_o),
        .irq_o     (cpu_irq_o)
    );

    assign stat_w0_o = stat[WORD_W-1:0];
    assign stat_w1_o = stat[STAT_W-1:WORD_W];

    AST_SUMMARY_TRACKS_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|{stat_w1_o, stat_w0_o}) == $past(|pin_pend_i)); // R2
    AST_EOI_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mst_wr_en_i |=> (mst_rd_data_o[MST_EOI_BIT] == 1'b0)); // R8

endmodule

// File: tb/test_irq_group_summary.sv
module test_irq_group_summary;

    localparam int NP = 184;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [31:0]   w0, w1;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_group_summary i_irq_group_summary (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .pin_pend_i    (pins),
        .mst_wr_en_i   (wr_en),
        .mst_wr_data_i (wr_data),
        .mst_rd_data_o (rd_data),
        .stat_w0_o     (w0),
        .stat_w1_o     (w1),
        .cpu_irq_o     (irq)
    );

    typedef struct packed {
        logic [NP-1:0] pv;
        logic [31:0]   e0;
        logic [31:0]   e1;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{pv: (184'd1 << 0),   e0: 32'h0000_0001, e1: 32'h0000_0000},
        '{pv: (184'd1 << 3),   e0: 32'h0000_0001, e1: 32'h0000_0000},
        '{pv: (184'd1 << 4),   e0: 32'h0000_0002, e1: 32'h0000_0000},
        '{pv: (184'd1 << 64),  e0: 32'h0001_0000, e1: 32'h0000_0000},
        '{pv: (184'd1 << 127), e0: 32'h8000_0000, e1: 32'h0000_0000},
        '{pv: (184'd1 << 128), e0: 32'h0000_0000, e1: 32'h0000_0001},
        '{pv: (184'd1 << 183), e0: 32'h0000_0000, e1: 32'h0000_2000},
        '{pv: (184'h8421),     e0: 32'h0000_000F, e1: 32'h0000_0000},
        '{pv: {NP{1'b1}},      e0: 32'hFFFF_FFFF, e1: 32'h0000_3FFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mst_write(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 w0", w0, 0);
        chk("R1 w1", w1, 0);
        chk("R1 rd", rd_data, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk with line disabled: R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            pins = VECS[i].pv;
            @(negedge clk);
            chk("R2_R3 w0", w0, VECS[i].e0);
            chk("R3_R4 w1", w1, VECS[i].e1);
            chk("R9 irq off", irq, 0);
        end
        pins = '0;
        @(negedge clk);
        chk("R2 cleared", {w1, w0}, 0);

        // enable, read back
        mst_write(32'h1);
        chk("R8 enable readback", rd_data, 32'h1);
        chk("R5 no pending no line", irq, 0);

        // raise on pending pin 50 (group 12)
        pins = 184'd1 << 50;
        @(negedge clk);
        chk("R2 group12", w0, 32'h0000_1000);
        chk("R5 not yet", irq, 0);
        @(negedge clk);
        chk("R5 raised", irq, 1);

        // hold after pins clear
        pins = '0;
        repeat (3) @(negedge clk);
        chk("R6 held", irq, 1);
        chk("R6 status clear", {w1, w0}, 0);

        // end-of-service with nothing pending
        mst_write(32'h3);
        chk("R7 dropped", irq, 0);
        chk("R8 eoi reads 0", rd_data, 32'h1);
        repeat (2) @(negedge clk);
        chk("R7 stays low", irq, 0);

        // re-raise after end-of-service while still pending (pin 100, group 25)
        pins = 184'd1 << 100;
        repeat (2) @(negedge clk);
        chk("R5 raised again", irq, 1);
        mst_write(32'h3);
        chk("R7 low after eoi", irq, 0);
        @(negedge clk);
        chk("R7 re-raised", irq, 1);

        // disable while pending
        mst_write(32'h0);
        chk("R9 dropped", irq, 0);
        chk("R8 disabled readback", rd_data, 0);
        repeat (3) @(negedge clk);
        chk("R9 stays low", irq, 0);
        chk("R9 status tracks", w0, 32'h0200_0000);
        chk("R4 upper zero", w1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule